// File: doc/BRIEF.md
# Microsecond Timebase with Match Alarms

This block keeps a free-running 64-bit time value that advances by one each microsecond. A parameterized divider derives the one-microsecond step from the system clock. Software on a 32-bit register bus reads the time in two halves. Reading the low half through the latched address copies the high half into a holding register. The following read of the latched high address then returns a high half that belongs with the low half already read, even if a carry happened in between. Two raw addresses return the live halves and change nothing.

Four alarm comparators watch the low 32 bits of the time. Writing a value into an alarm arms it. When an armed alarm's value equals the low word, the alarm disarms and raises its interrupt flag. The flag drives a level output until software clears it by writing 1. A one-cycle pulse output marks each firing. A pause register freezes both the divider phase and the counter.

Top module: `timer64_us`

## Requirements
- R1: While not paused, the 64-bit count increases by exactly one every CLKS_PER_US clock cycles. A carry out of the low 32 bits goes into the high 32 bits.
- R2: While bit 0 of the pause register (offset 0x30) is 1, the count and the divider phase hold their values. Counting resumes when the bit is written back to 0.
- R3: A read of offset 0x0C returns the live low word and copies the live high word into a holding register. A read of offset 0x08 returns the holding register.
- R4: Reads of offsets 0x24 (high) and 0x28 (low) return the live halves and leave the holding register unchanged.
- R5: Writing alarm i (offset 0x10 + 4*i, i = 0..3) stores the 32-bit value, which reads back at the same offset. The write also sets bit i of the armed register (offset 0x20).
- R6: When alarm i is armed and its value equals the low word of the count, armed bit i clears and interrupt flag i sets. An alarm fires once per arming.
- R7: A write to offset 0x20 clears every armed bit whose data bit is 0. A data bit of 1 changes nothing.
- R8: Interrupt flags read at offset 0x34 (bit i for alarm i) and drive irq_level[i]. A flag stays set until a write to 0x34 with bit i = 1. A write with bit i = 0 leaves it set.
- R9: irq_pulse[i] is high for exactly one clock each time alarm i fires.
- R10: After reset the count equals INIT_COUNT, and the alarm values, armed bits, flags and pause bit are all 0.
- R11: Read data appears on bus_rdata in the cycle after the cycle that bus_rd is high. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_level | output | 4 | Per-alarm interrupt flags |
| irq_pulse | output | 4 | One-cycle strobe per alarm firing |

## Verification
The bench starts the count just below a low-word rollover. This lets it check that the held high word keeps the pre-carry value after the carry, while raw reads show the new one. A design that refreshed the hold on a raw read, or that never latched, would return the wrong high word. Alarms are tested for the exact firing value, for a single pulse per arming, and for not firing while paused even though their value is reached only after resuming. A design that re-fired while the low word held its value, or that compared while paused, would show extra pulses or an early flag. The bench also covers cancelling with 0 bits, write-1 bits that must not arm anything, and flag clears that must touch only the selected bit.

// File: rtl/timer64_pkg.sv
// Package: register offsets and helpers shared by the timebase modules.
// Assumes an 8-bit byte-offset bus and four alarms at consecutive words.
package timer64_pkg;
    localparam int NUM_ALARMS = 4;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;

    typedef logic [ADDR_W-1:0] reg_off_t;

    localparam reg_off_t OFF_LAT_HI = 8'h08;
    localparam reg_off_t OFF_LAT_LO = 8'h0C;
    localparam reg_off_t OFF_ALARM0 = 8'h10;
    localparam reg_off_t OFF_ARMED  = 8'h20;
    localparam reg_off_t OFF_RAW_HI = 8'h24;
    localparam reg_off_t OFF_RAW_LO = 8'h28;
    localparam reg_off_t OFF_PAUSE  = 8'h30;
    localparam reg_off_t OFF_IRQ    = 8'h34;

    // Offset of alarm register idx.
    function automatic reg_off_t alarm_off(input int idx);
        return reg_off_t'(int'(OFF_ALARM0) + 4 * idx);
    endfunction
endpackage

// File: rtl/timer64_tick_div.sv
// Module: divides the system clock into a one-cycle tick every CLKS_PER_US
// cycles. Assumes CLKS_PER_US >= 1. While hold is high the phase is frozen
// and no tick is issued.
module timer64_tick_div #(
    parameter int CLKS_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] phase_q;

    // Tick on the last phase unless frozen.
    assign tick = !hold && (phase_q == LAST);

    // Advance the phase, wrapping at LAST, frozen while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!hold) begin
            if (phase_q == LAST) phase_q <= '0;
            else                 phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/timer64_counter.sv
// Module: 64-bit time value that increments on each tick.
// Assumes the tick lasts one cycle per microsecond. Resets to INIT_COUNT.
module timer64_counter #(
    parameter logic [63:0] INIT_COUNT = 64'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    output logic [63:0] count
);
    // Step the count by one on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= INIT_COUNT;
        else if (tick) count <= count + 64'd1;
    end
endmodule

// File: rtl/timer64_alarm.sv
// Module: one alarm comparator with an armed bit, a sticky interrupt flag
// and a one-cycle pulse. Assumes set_val, cancel and clr_flag are
// single-cycle strobes from the register decoder. A write that arms in the
// same cycle as a match rearms the alarm, and the match still raises the flag.
module timer64_alarm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_val,
    input  logic [31:0] wdata,
    input  logic        cancel,
    input  logic        clr_flag,
    input  logic [31:0] count_lo,
    output logic [31:0] value,
    output logic        armed,
    output logic        flag,
    output logic        pulse
);
    logic fire;

    // Match only while armed.
    assign fire = armed && (count_lo == value);

    // Hold the compare value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (set_val) value <= wdata;
    end

    // Arm on write; disarm on firing or on cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b0;
        else if (set_val)          armed <= 1'b1;
        else if (fire || cancel)   armed <= 1'b0;
    end

    // Sticky flag: set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (fire)     flag <= 1'b1;
        else if (clr_flag) flag <= 1'b0;
    end

    // One-cycle strobe marking the firing.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= fire;
    end
endmodule

// File: rtl/timer64_us.sv
// Module: memory-mapped 64-bit microsecond timebase with four low-word
// alarms. Assumes single-cycle read and write strobes that never occur
// together. Read data is registered and valid the cycle after bus_rd.
module timer64_us
    import timer64_pkg::*;
#(
    parameter int          CLKS_PER_US = 50,
    parameter logic [63:0] INIT_COUNT  = 64'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [3:0]  irq_level,
    output logic [3:0]  irq_pulse
);
    logic                  tick;
    logic [63:0]           count_q;
    logic                  paused_q;
    logic [31:0]           hold_hi_q;
    logic [NUM_ALARMS-1:0] armed_vec;
    logic [31:0]           alarm_val [NUM_ALARMS];
    logic [31:0]           rd_mux;

    timer64_tick_div #(.CLKS_PER_US(CLKS_PER_US)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (paused_q),
        .tick  (tick)
    );

    timer64_counter #(.INIT_COUNT(INIT_COUNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count_q)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ALARMS; gi++) begin : g_alarm
            timer64_alarm u_alarm (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_val  (bus_wr && (bus_addr == alarm_off(gi))),
                .wdata    (bus_wdata),
                .cancel   (bus_wr && (bus_addr == OFF_ARMED) && !bus_wdata[gi]),
                .clr_flag (bus_wr && (bus_addr == OFF_IRQ) && bus_wdata[gi]),
                .count_lo (count_q[31:0]),
                .value    (alarm_val[gi]),
                .armed    (armed_vec[gi]),
                .flag     (irq_level[gi]),
                .pulse    (irq_pulse[gi])
            );
        end
    endgenerate

    // Pause control register, bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                paused_q <= 1'b0;
        else if (bus_wr && bus_addr == OFF_PAUSE)  paused_q <= bus_wdata[0];
    end

    // Capture the high word when the latched low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                hold_hi_q <= '0;
        else if (bus_rd && bus_addr == OFF_LAT_LO) hold_hi_q <= count_q[63:32];
    end

    // Select read data by offset; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFF_LAT_HI: rd_mux = hold_hi_q;
            OFF_LAT_LO: rd_mux = count_q[31:0];
            OFF_RAW_HI: rd_mux = count_q[63:32];
            OFF_RAW_LO: rd_mux = count_q[31:0];
            OFF_ARMED:  rd_mux = 32'(armed_vec);
            OFF_PAUSE:  rd_mux = 32'(paused_q);
            OFF_IRQ:    rd_mux = 32'(irq_level);
            default:    rd_mux = '0;
        endcase
        for (int i = 0; i < NUM_ALARMS; i++) begin
            if (bus_addr == alarm_off(i)) rd_mux = alarm_val[i];
        end
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/timer64_us_chk.sv
// Module: property checker bound to timer64_us. Watches the count, the
// pause state, the armed bits and the interrupt outputs.
module timer64_us_chk
    import timer64_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  irq_level,
    input logic [3:0]  irq_pulse,
    input logic [63:0] count_q,
    input logic        paused_q,
    input logic [3:0]  armed_vec
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> (count_q == $past(count_q) + 64'd1)); // R1

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        paused_q |=> $stable(count_q)); // R2

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ALARMS; gi++) begin : g_chk
            AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == alarm_off(gi)) |=> armed_vec[gi]); // R5

            AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_pulse[gi]) |-> ($past(armed_vec[gi]) && !armed_vec[gi] && irq_level[gi])); // R6

            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_level[gi] && !(bus_wr && bus_addr == OFF_IRQ && bus_wdata[gi]))
                |=> irq_level[gi]); // R8

            AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                irq_pulse[gi] |=> !irq_pulse[gi]); // R9
        end
    endgenerate
endmodule

bind timer64_us timer64_us_chk u_chk (.*);

// File: tb/tb_timer64_us.sv
// Directed bench for timer64_us: one task per scenario, each self-checking.
module tb_timer64_us;
    localparam int          DIV  = 5;
    localparam logic [63:0] INIT = 64'h0000_0005_FFFF_FFC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_level;
    logic [3:0]  irq_pulse;

    int checks = 0;
    int errors = 0;
    int pcnt [4];
    bit done = 0;

    timer64_us #(.CLKS_PER_US(DIV), .INIT_COUNT(INIT)) dut (.*);

    always #10 clk = ~clk;

    // Count pulses per alarm, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n) for (int i = 0; i < 4; i++) pcnt[i] += int'(irq_pulse[i]);
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int idx, input int limit, output bit seen);
        seen = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (irq_level[idx]) begin seen = 1; break; end
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h28, d); check("R10 raw lo after reset", d, INIT[31:0]);
        rd(8'h24, d); check("R10 raw hi after reset", d, INIT[63:32]);
        rd(8'h20, d); check("R10 armed after reset", d, 0);
        rd(8'h34, d); check("R10 irq after reset", d, 0);
        rd(8'h10, d); check("R10 alarm0 after reset", d, 0);
        rd(8'h30, d); check("R10 pause after reset", d, 0);
        check("R10 irq_level pins", irq_level, 0);
    endtask

    task automatic t_latch;
        logic [31:0] d;
        rd(8'h0C, d);
        check("R3 latched lo before carry", 64'(d[31:28]), 64'hF);
        repeat (400) @(negedge clk);
        rd(8'h24, d); check("R1 carry into raw hi", d, 6);
        rd(8'h28, d);
        rd(8'h08, d); check("R4 raw reads keep hold", d, 5);
        rd(8'h0C, d);
        rd(8'h08, d); check("R3 hold refreshed", d, 6);
    endtask

    task automatic t_rate;
        logic [31:0] a, b;
        rd(8'h28, a);
        repeat (48) @(negedge clk);
        rd(8'h28, b);
        check("R1 ten ticks in 50 clocks", b - a, 10);
        rd(8'h00, a); check("R11 unmapped 0x00", a, 0);
        rd(8'h2C, a); check("R11 unmapped 0x2C", a, 0);
    endtask

    task automatic t_pause;
        logic [31:0] a, b;
        wr(8'h30, 1);
        rd(8'h30, a); check("R2 pause readback", a, 1);
        rd(8'h28, a);
        repeat (60) @(negedge clk);
        rd(8'h28, b); check("R2 count frozen", b, a);
        wr(8'h30, 0);
        repeat (60) @(negedge clk);
        rd(8'h28, b); check("R2 count resumes", 64'(b != a), 1);
    endtask

    task automatic t_fire;
        logic [31:0] v, d;
        bit seen;
        rd(8'h28, v);
        wr(8'h10, v + 12);
        rd(8'h20, d); check("R5 armed bit0 set", d, 1);
        rd(8'h10, d); check("R5 alarm0 readback", d, v + 12);
        pcnt[0] = 0;
        wait_irq(0, 200, seen);
        check("R6 alarm0 fired", 64'(seen), 1);
        rd(8'h28, d);
        check("R6 fired at match value", 64'(d == v + 12 || d == v + 13), 1);
        rd(8'h20, d); check("R6 armed bit0 cleared", d, 0);
        rd(8'h34, d); check("R8 irq status bit0", d, 1);
        repeat (40) @(negedge clk);
        check("R9 one pulse per firing", pcnt[0], 1);
        check("R8 flag still set", irq_level, 4'b0001);
        wr(8'h34, 0);
        check("R8 write 0 keeps flag", irq_level, 4'b0001);
        wr(8'h34, 1);
        check("R8 write 1 clears flag", irq_level, 4'b0000);
    endtask

    task automatic t_multi;
        logic [31:0] v;
        bit s1, s3;
        rd(8'h28, v);
        wr(8'h14, v + 8);
        wr(8'h1C, v + 8);
        wait_irq(1, 200, s1);
        wait_irq(3, 20, s3);
        check("R6 alarm1 and alarm3 fire", {s1, s3}, 2'b11);
        wr(8'h34, 32'h2);
        check("R8 clear only bit1", irq_level, 4'b1000);
        wr(8'h34, 32'h8);
        check("R8 bit3 cleared", irq_level, 4'b0000);
    endtask

    task automatic t_cancel;
        logic [31:0] v, d;
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); check("R7 write 1 arms nothing", d, 0);
        rd(8'h28, v);
        wr(8'h18, v + 8);
        wr(8'h20, 32'hFFFF_FFFB);
        rd(8'h20, d); check("R7 bit2 cancelled", d, 0);
        pcnt[2] = 0;
        repeat (100) @(negedge clk);
        check("R7 cancelled alarm silent", irq_level, 0);
        check("R9 no pulse after cancel", pcnt[2], 0);
    endtask

    task automatic t_paused_alarm;
        logic [31:0] p, d;
        bit seen;
        wr(8'h30, 1);
        rd(8'h28, p);
        wr(8'h10, p + 1);
        repeat (40) @(negedge clk);
        check("R2 no fire while paused", irq_level, 0);
        rd(8'h20, d); check("R5 still armed while paused", d, 1);
        wr(8'h30, 0);
        wait_irq(0, 40, seen);
        check("R6 fires after resume", 64'(seen), 1);
        wr(8'h34, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_rate();
        t_pause();
        t_fire();
        t_multi();
        t_cancel();
        t_paused_alarm();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule